// File: doc/BRIEF.md
# Bit-Parallel Stuck-At Fault Evaluator

This block grades test patterns against single stuck-at faults in a small fixed logic cone, F = (A AND B) OR (NOT C). It does not evaluate one copy of the cone at a time. It evaluates thirteen copies in the same cycle, one copy in each bit of a word. Bit 0 holds the fault-free copy. Each of the other twelve bits holds a copy in which exactly one site is forced permanently low or permanently high. The sites are the three input ports, the AND output, the inverter output and F.

A pattern is applied on the three inputs together with a one-cycle strobe. At the clock edge the block compares every faulty copy's F with the good copy's F. It registers the per-fault difference as a hit mask and ORs it into sticky detected flags. A synchronous clear empties the flags. A population count of the flags gives fault cover directly, as detected faults out of twelve.

Top module: `sa_word_eval`

## Requirements
- R1: After reset, hit_mask, det_flags and det_count are all zero.
- R2: Fault bit mapping: the sites are numbered A=0, B=1, C=2, AND output=3, inverter output=4, F=5. Site s stuck at 0 occupies bit 2s+1 and site s stuck at 1 occupies bit 2s+2. On a cycle with strobe=1, hit_mask takes, one clock later, bit k set exactly when copy k's F differs from the good F for the applied in_a/in_b/in_c.
- R3: The AND-output stuck-at-0 copy (bit 7) is hit only by the pattern in_a=1, in_b=1, in_c=1.
- R4: Bit 0, the good copy, is never set in hit_mask or det_flags.
- R5: det_flags is sticky. With clr=0, a strobe ORs the new hit mask into the flags and never clears a set flag.
- R6: On a cycle with strobe=0, input changes have no effect, and hit_mask and det_flags keep their values.
- R7: clr=1 empties det_flags at the next edge. It takes priority over a strobe in the same cycle, although that strobe still updates hit_mask.
- R8: det_count always equals the number of set bits in det_flags.
- R9: After all eight input patterns have been strobed, all twelve faults are flagged and det_count reads 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of the detected flags |
| strobe | input | 1 | Compare and record the current pattern |
| in_a | input | 1 | Pattern bit A |
| in_b | input | 1 | Pattern bit B |
| in_c | input | 1 | Pattern bit C |
| hit_mask | output | 13 | Faults revealed by the last strobed pattern |
| det_flags | output | 13 | Sticky detected flags, bit 0 always 0 |
| det_count | output | 4 | Number of flagged faults |

## Verification
The bench builds the block at its only configuration, six sites and a 13-bit word. At this size the input space has eight patterns, so a directed sweep covers every pattern and shows full cover being reached. The sweep also isolates the pattern that reveals the AND stuck-at-0 fault. Seeded random sequences of strobe, clear and input changes then test flag accumulation, clear priority and holding between strobes, against a scalar per-fault model that is evaluated one copy at a time.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int NSITE  = 6;
  localparam int WORD_W = 2 * NSITE + 1;
  localparam int CNT_W  = $clog2(WORD_W);

  localparam int SITE_A   = 0;
  localparam int SITE_B   = 1;
  localparam int SITE_C   = 2;
  localparam int SITE_AND = 3;
  localparam int SITE_INV = 4;
  localparam int SITE_F   = 5;

  typedef logic [WORD_W-1:0] word_t;

  // bit that carries site s stuck at the given level
  function automatic int fault_bit(input int s, input bit level);
    return 2 * s + 1 + (level ? 1 : 0);
  endfunction

  // apply per-copy forcing to a word of net values
  function automatic word_t force_net(input word_t v, input word_t m0, input word_t m1);
    return (v & ~m0) | m1;
  endfunction

  function automatic logic [CNT_W-1:0] popcount(input word_t w);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < WORD_W; i++) n = n + CNT_W'(w[i]);
    return n;
  endfunction
endpackage

// File: rtl/sa_mask_gen.sv
module sa_mask_gen
  import sa_pkg::*;
(
  output word_t sa0_mask [NSITE],
  output word_t sa1_mask [NSITE]
);
  for (genvar s = 0; s < NSITE; s++) begin : g_site
    localparam int B0 = 2 * s + 1;
    localparam int B1 = 2 * s + 2;
    assign sa0_mask[s] = word_t'(1) << B0;
    assign sa1_mask[s] = word_t'(1) << B1;
  end
endmodule

// File: rtl/sa_eval_core.sv
module sa_eval_core
  import sa_pkg::*;
(
  input  logic  in_a,
  input  logic  in_b,
  input  logic  in_c,
  input  word_t sa0_mask [NSITE],
  input  word_t sa1_mask [NSITE],
  output word_t f_word
);
  word_t a_w, b_w, c_w, and_w, inv_w;

  always_comb begin
    a_w    = force_net({WORD_W{in_a}}, sa0_mask[SITE_A], sa1_mask[SITE_A]);
    b_w    = force_net({WORD_W{in_b}}, sa0_mask[SITE_B], sa1_mask[SITE_B]);
    c_w    = force_net({WORD_W{in_c}}, sa0_mask[SITE_C], sa1_mask[SITE_C]);
    and_w  = force_net(a_w & b_w, sa0_mask[SITE_AND], sa1_mask[SITE_AND]);
    inv_w  = force_net(~c_w, sa0_mask[SITE_INV], sa1_mask[SITE_INV]);
    f_word = force_net(and_w | inv_w, sa0_mask[SITE_F], sa1_mask[SITE_F]);
  end
endmodule

// File: rtl/sa_compare.sv
module sa_compare
  import sa_pkg::*;
(
  input  word_t f_word,
  output word_t diff
);
  // every copy against the good copy in bit 0; bit 0 compares to itself
  assign diff = f_word ^ {WORD_W{f_word[0]}};
endmodule

// File: rtl/sa_sticky.sv
module sa_sticky
  import sa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             strobe,
  input  word_t            diff,
  output word_t            hit_mask,
  output word_t            det_flags,
  output logic [CNT_W-1:0] det_count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_mask  <= '0;
      det_flags <= '0;
    end else begin
      if (strobe) hit_mask <= diff;
      if (clr) det_flags <= '0;
      else if (strobe) det_flags <= det_flags | diff;
    end
  end

  assign det_count = popcount(det_flags);
endmodule

// File: rtl/sa_word_eval.sv
module sa_word_eval
  import sa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              strobe,
  input  logic              in_a,
  input  logic              in_b,
  input  logic              in_c,
  output logic [WORD_W-1:0] hit_mask,
  output logic [WORD_W-1:0] det_flags,
  output logic [CNT_W-1:0]  det_count
);
  word_t sa0_mask [NSITE];
  word_t sa1_mask [NSITE];
  word_t f_word;
  word_t cmp_diff;

  sa_mask_gen u_masks (.sa0_mask(sa0_mask), .sa1_mask(sa1_mask));

  sa_eval_core u_core (
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .sa0_mask(sa0_mask), .sa1_mask(sa1_mask), .f_word(f_word)
  );

  sa_compare u_cmp (.f_word(f_word), .diff(cmp_diff));

  sa_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .clr(clr), .strobe(strobe), .diff(cmp_diff),
    .hit_mask(hit_mask), .det_flags(det_flags), .det_count(det_count)
  );
endmodule

// File: rtl/sa_word_eval_chk.sv
module sa_word_eval_chk
  import sa_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              strobe,
  input logic              in_a,
  input logic              in_b,
  input logic              in_c,
  input logic [WORD_W-1:0] cmp_diff,
  input logic [WORD_W-1:0] hit_mask,
  input logic [WORD_W-1:0] det_flags,
  input logic [CNT_W-1:0]  det_count
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  // R4
  good_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_mask[0] && !det_flags[0] && !cmp_diff[0]);

  // R6
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !strobe |=> $stable(hit_mask));

  // R5
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !clr |=> ((det_flags & $past(det_flags)) == $past(det_flags)));

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    clr |=> (det_flags == '0));

  // R8
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_count == CNT_W'($countones(det_flags)));

  // R3
  and_sa0_only_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (strobe && !(in_a && in_b && in_c)) |=> !hit_mask[7]);
endmodule

bind sa_word_eval sa_word_eval_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .strobe(strobe),
  .in_a(in_a), .in_b(in_b), .in_c(in_c), .cmp_diff(cmp_diff),
  .hit_mask(hit_mask), .det_flags(det_flags), .det_count(det_count)
);

// File: tb/sa_word_eval_test.sv
`timescale 1ns/1ps
module sa_word_eval_test;
  localparam int W = 13;

  logic clk = 0, rst_n = 0, clr = 0, strobe = 0, in_a = 0, in_b = 0, in_c = 0;
  logic [W-1:0] hit_mask, det_flags;
  logic [3:0] det_count;
  int checks = 0, fails = 0, cycles = 0;
  logic [W-1:0] exp_hit = '0, exp_flags = '0;

  always #2.5 clk = ~clk;

  sa_word_eval uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .strobe(strobe),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .hit_mask(hit_mask), .det_flags(det_flags), .det_count(det_count)
  );

  // scalar model: one circuit copy, fault id 0 = none, else site (id-1)/2 stuck at (id-1)%2
  function automatic bit model_f(bit a, bit b, bit c, int id);
    int site; bit lvl; bit na, nb, nc, nand_, ninv, nf;
    site = (id == 0) ? -1 : (id - 1) / 2;
    lvl  = (id == 0) ? 1'b0 : bit'((id - 1) % 2);
    na = (site == 0) ? lvl : a;
    nb = (site == 1) ? lvl : b;
    nc = (site == 2) ? lvl : c;
    nand_ = (site == 3) ? lvl : (na & nb);
    ninv  = (site == 4) ? lvl : ~nc;
    nf    = (site == 5) ? lvl : (nand_ | ninv);
    return nf;
  endfunction

  function automatic logic [W-1:0] model_mask(bit a, bit b, bit c);
    logic [W-1:0] m = '0;
    for (int k = 1; k < W; k++) m[k] = model_f(a, b, c, k) != model_f(a, b, c, 0);
    return m;
  endfunction

  function automatic int ones(logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, let one edge pass, check at next negedge
  task automatic step(bit a, bit b, bit c, bit stb, bit cl);
    in_a = a; in_b = b; in_c = c; strobe = stb; clr = cl;
    @(posedge clk);
    if (stb) exp_hit = model_mask(a, b, c);
    if (cl) exp_flags = '0;
    else if (stb) exp_flags = exp_flags | model_mask(a, b, c);
    @(negedge clk);
    chk("R2", "hit_mask", hit_mask, exp_hit);
    chk("R5", "det_flags", det_flags, exp_flags);
    chk("R8", "det_count", det_count, ones(exp_flags));
    chk("R4", "good bit", {hit_mask[0], det_flags[0]}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1", "hit_mask reset", hit_mask, 0);
    chk("R1", "det_flags reset", det_flags, 0);
    chk("R1", "det_count reset", det_count, 0);

    // exhaustive sweep, R3 per pattern
    for (int p = 0; p < 8; p++) begin
      step(p[2], p[1], p[0], 1, 0);
      chk("R3", "AND sa0 bit7", hit_mask[7], (p == 7) ? 1 : 0);
    end
    // R9
    chk("R9", "full cover count", det_count, 12);
    chk("R9", "full cover flags", det_flags, 13'h1FFE);

    // R6: inputs toggle without strobe
    step(1, 1, 1, 1, 1);
    for (int p = 0; p < 8; p++) step(p[0], p[1], p[2], 0, 0);
    chk("R6", "hold hit_mask", hit_mask, model_mask(1, 1, 1));
    chk("R6", "hold flags", det_flags, 0);

    // R7: clear with strobe same cycle
    step(0, 1, 1, 1, 0);
    step(0, 0, 0, 1, 1);
    chk("R7", "clr priority flags", det_flags, 0);
    chk("R7", "clr strobe hit", hit_mask, model_mask(0, 0, 0));

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [4:0] r = 5'($urandom);
      step(r[0], r[1], r[2], r[3], (r[4] && ($urandom % 4 == 0)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end
endmodule